// File: doc/BRIEF.md
# Byte-Port Command and Address Loader

This block sits behind an 8-bit port that carries both user data and control traffic. The only thing that sets a control byte apart is a command flag sampled with the write strobe. While the block is idle, a flagged byte is decoded as a command. A setup command takes the next six unflagged strobed bytes as a start address and an end address. A write or read command then opens a transfer. During a transfer each unflagged strobe counts one data word, and no per-word addressing is needed.

The block holds a current word address and moves it one burst of eight words at a time. It pulses an increment strobe whenever a burst completes and more data remains. It pulses a done signal on the burst that contains the end address and then returns to idle, so the address never runs past the preloaded range. A neighbouring sequencer uses the address, the increment strobe, the mode outputs and the done pulse to drive the memory. Byte synchronisation, data widening and memory sequencing are outside this block.

The controller has four states. Idle (ST_IDLE) is the only state that accepts commands. Parameter collection (ST_PARAM) is entered from idle on a setup command and returns to idle after the sixth byte. Write transfer (ST_WRITE) and read transfer (ST_READ) are entered from idle on a write or read command and return to idle after the final burst.

Top module: `byte_cmd_loader`

## Requirements
- R1: After reset, busy, err, wr_active, rd_active, addr_step and xfer_done are all 0, and word_addr is 0 with the stored end address also 0.
- R2: In idle, a strobed byte with cmd_flag high is decoded as a command: 8'h01 setup, 8'h02 write, 8'h03 read, 8'h04 stop. A strobed byte with cmd_flag low in idle changes nothing.
- R3: While busy, a strobed byte with cmd_flag high is ignored. It is not counted as a parameter or data word, and state, address and error status are left unchanged.
- R4: After setup, busy is high while six unflagged strobed bytes are taken: start address first and end address second, each most significant byte first. One cycle after the sixth byte, busy is low and word_addr equals the start address.
- R5: From the cycle after a write command wr_active and busy are high, and from the cycle after a read command rd_active and busy are high. The two never rise together, and both drop when the transfer ends.
- R6: During a transfer, every eighth unflagged strobe completes a burst. If that burst is not the last one, word_addr increases by 8 in the next cycle and addr_step pulses high for exactly that cycle.
- R7: A burst is the last one when word_addr + 8 exceeds the end address; this includes a start address above the end address and an address near the top of the range. When the last burst completes, xfer_done pulses for one cycle, busy drops, and word_addr keeps the base of that burst.
- R8: A flagged byte in idle with any code other than 8'h01 to 8'h04 sets err and leaves the block idle. Any valid command accepted in idle clears err.
- R9: A stop command (8'h04) in idle clears err and leaves state and address unchanged.
- R10: In a cycle with rx_stb low, no state, address, pulse or error output changes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Synchronised byte from the shared port |
| rx_stb | input | 1 | Byte strobe, one cycle per byte |
| cmd_flag | input | 1 | Marks the strobed byte as a command |
| busy | output | 1 | High whenever the controller is not idle |
| err | output | 1 | Sticky unknown-command status |
| wr_active | output | 1 | Write transfer in progress |
| rd_active | output | 1 | Read transfer in progress |
| word_addr | output | 24 | Current word address (burst base) |
| addr_step | output | 1 | One-cycle pulse: address advanced by one burst |
| xfer_done | output | 1 | One-cycle pulse: final burst completed |

## Verification
Some properties are checked on every cycle. A flagged byte while busy leaves the address and pulses untouched. An addr_step pulse always comes with an address exactly 8 higher. A done pulse coincides with idle and an unchanged address. The two pulses never coincide, and a strobe-free cycle changes nothing. Some behaviour only the scenarios can show: the byte order of the loaded addresses, the exact burst on which a range ends (including start above end and the top of the address space), and the way err is set and cleared across a sequence of commands. The bench's behavioural model covers these.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PARAM,
        ST_WRITE,
        ST_READ
    } ldr_state_e;

    typedef enum logic [2:0] {
        CK_SETUP,
        CK_WRITE,
        CK_READ,
        CK_STOP,
        CK_BAD
    } cmd_kind_e;

    localparam logic [7:0] CODE_SETUP = 8'h01;
    localparam logic [7:0] CODE_WRITE = 8'h02;
    localparam logic [7:0] CODE_READ  = 8'h03;
    localparam logic [7:0] CODE_STOP  = 8'h04;

endpackage

// File: rtl/bcl_cmd_decoder.sv
module bcl_cmd_decoder
    import bcl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] code,
    output cmd_kind_e         kind
);

    always_comb begin
        case (code)
            BYTE_W'(CODE_SETUP): kind = CK_SETUP;
            BYTE_W'(CODE_WRITE): kind = CK_WRITE;
            BYTE_W'(CODE_READ):  kind = CK_READ;
            BYTE_W'(CODE_STOP):  kind = CK_STOP;
            default:             kind = CK_BAD;
        endcase
    end

endmodule

// File: rtl/bcl_param_collector.sv
module bcl_param_collector #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     take,
    input  logic [BYTE_W-1:0]        din,
    output logic                     last,
    output logic [NBYTES*BYTE_W-1:0] full
);

    localparam int CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int HELD  = NBYTES - 1;

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] stage [HELD];

    assign last = take && (cnt == CNT_W'(NBYTES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // stage[0] holds the newest byte, stage[HELD-1] the oldest
    genvar gi;
    generate
        for (gi = 0; gi < HELD; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[gi] <= '0;
                end else if (take) begin
                    if (gi == 0) begin
                        stage[gi] <= din;
                    end else begin
                        stage[gi] <= stage[gi-1];
                    end
                end
            end
            assign full[(gi+2)*BYTE_W-1 -: BYTE_W] = stage[gi];
        end
    endgenerate

    assign full[BYTE_W-1:0] = din;

endmodule

// File: rtl/bcl_addr_walker.sv
module bcl_addr_walker #(
    parameter int ADDR_W    = 24,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_in,
    input  logic [ADDR_W-1:0] end_in,
    input  logic              begin_xfer,
    input  logic              beat,
    output logic [ADDR_W-1:0] word_addr,
    output logic              burst_end,
    output logic              last_burst,
    output logic              addr_step,
    output logic              xfer_done
);

    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic [BEAT_W-1:0] beat_cnt;
    logic [ADDR_W-1:0] end_addr;
    logic [ADDR_W:0]   reach;

    assign reach      = {1'b0, word_addr} + (ADDR_W+1)'(BURST_LEN);
    assign last_burst = reach > {1'b0, end_addr};
    assign burst_end  = beat && (beat_cnt == BEAT_W'(BURST_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || begin_xfer) begin
            beat_cnt <= '0;
        end else if (beat) begin
            beat_cnt <= burst_end ? '0 : beat_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_addr <= '0;
            end_addr  <= '0;
        end else if (load) begin
            word_addr <= start_in;
            end_addr  <= end_in;
        end else if (burst_end && !last_burst) begin
            word_addr <= reach[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_step <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            addr_step <= burst_end && !last_burst;
            xfer_done <= burst_end && last_burst;
        end
    end

endmodule

// File: rtl/byte_cmd_loader.sv
module byte_cmd_loader
    import bcl_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int ADDR_BYTES = 3,
    parameter int BURST_LEN  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BYTE_W-1:0]            rx_byte,
    input  logic                         rx_stb,
    input  logic                         cmd_flag,
    output logic                         busy,
    output logic                         err,
    output logic                         wr_active,
    output logic                         rd_active,
    output logic [ADDR_BYTES*BYTE_W-1:0] word_addr,
    output logic                         addr_step,
    output logic                         xfer_done
);

    localparam int ADDR_W  = ADDR_BYTES * BYTE_W;
    localparam int NPARAMS = 2 * ADDR_BYTES;

    ldr_state_e state, state_nx;
    cmd_kind_e  kind;

    logic cmd_stb, data_stb, in_idle, in_xfer;
    logic accept_cmd, param_clear, param_take, param_last;
    logic begin_xfer, beat, burst_end, last_burst;
    logic [NPARAMS*BYTE_W-1:0] param_word;

    assign cmd_stb  = rx_stb && cmd_flag;
    assign data_stb = rx_stb && !cmd_flag;
    assign in_idle  = (state == ST_IDLE);
    assign in_xfer  = (state == ST_WRITE) || (state == ST_READ);

    assign accept_cmd  = in_idle && cmd_stb;
    assign param_clear = accept_cmd && (kind == CK_SETUP);
    assign param_take  = (state == ST_PARAM) && data_stb;
    assign begin_xfer  = accept_cmd && ((kind == CK_WRITE) || (kind == CK_READ));
    assign beat        = in_xfer && data_stb;

    bcl_cmd_decoder #(.BYTE_W(BYTE_W)) u_dec (
        .code (rx_byte),
        .kind (kind)
    );

    bcl_param_collector #(.BYTE_W(BYTE_W), .NBYTES(NPARAMS)) u_param (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (param_clear),
        .take  (param_take),
        .din   (rx_byte),
        .last  (param_last),
        .full  (param_word)
    );

    bcl_addr_walker #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (param_last),
        .start_in   (param_word[NPARAMS*BYTE_W-1 -: ADDR_W]),
        .end_in     (param_word[ADDR_W-1:0]),
        .begin_xfer (begin_xfer),
        .beat       (beat),
        .word_addr  (word_addr),
        .burst_end  (burst_end),
        .last_burst (last_burst),
        .addr_step  (addr_step),
        .xfer_done  (xfer_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_stb) begin
                    case (kind)
                        CK_SETUP: state_nx = ST_PARAM;
                        CK_WRITE: state_nx = ST_WRITE;
                        CK_READ:  state_nx = ST_READ;
                        default:  state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_PARAM: if (param_last) state_nx = ST_IDLE;
            ST_WRITE: if (burst_end && last_burst) state_nx = ST_IDLE;
            ST_READ:  if (burst_end && last_burst) state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy      = 1'b1;
        wr_active = 1'b0;
        rd_active = 1'b0;
        unique case (state)
            ST_IDLE:  busy      = 1'b0;
            ST_PARAM: busy      = 1'b1;
            ST_WRITE: wr_active = 1'b1;
            ST_READ:  rd_active = 1'b1;
        endcase
    end

    // error status
    always_ff @(posedge clk) begin
        if (!rst_n)          err <= 1'b0;
        else if (accept_cmd) err <= (kind == CK_BAD);
    end

endmodule

// File: rtl/byte_cmd_loader_chk.sv
module byte_cmd_loader_chk #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              rx_stb,
    input logic              cmd_flag,
    input logic              busy,
    input logic              err,
    input logic              wr_active,
    input logic              rd_active,
    input logic [ADDR_W-1:0] word_addr,
    input logic              addr_step,
    input logic              xfer_done
);

    logic bad_code;
    assign bad_code = (rx_byte == '0) || (rx_byte > BYTE_W'(4));

    a_r3_flag_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_stb && cmd_flag) |=> (busy && !addr_step && !xfer_done && $stable(word_addr)));

    a_r5_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_active, rd_active}) && (!(wr_active || rd_active) || busy));

    a_r6_step_by_burst: assert property (@(posedge clk) disable iff (!rst_n)
        addr_step |-> (word_addr == $past(word_addr) + ADDR_W'(8)));

    a_r6_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_step && xfer_done));

    a_r7_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (!busy && $stable(word_addr)));

    a_r8_bad_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rx_stb && cmd_flag && bad_code) |=> (err && !busy));

    a_r10_quiet_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_stb |=> ($stable(word_addr) && $stable(busy) && $stable(err) && !addr_step && !xfer_done));

endmodule

bind byte_cmd_loader byte_cmd_loader_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_BYTES*BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .rx_stb    (rx_stb),
    .cmd_flag  (cmd_flag),
    .busy      (busy),
    .err       (err),
    .wr_active (wr_active),
    .rd_active (rd_active),
    .word_addr (word_addr),
    .addr_step (addr_step),
    .xfer_done (xfer_done)
);

// File: tb/byte_cmd_loader_bench.sv
`timescale 1ns/1ps
module byte_cmd_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_stb = 1'b0;
    logic        cmd_flag = 1'b0;
    logic        busy, err, wr_active, rd_active, addr_step, xfer_done;
    logic [23:0] word_addr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    byte_cmd_loader u_byte_cmd_loader (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_stb(rx_stb), .cmd_flag(cmd_flag),
        .busy(busy), .err(err), .wr_active(wr_active), .rd_active(rd_active),
        .word_addr(word_addr), .addr_step(addr_step), .xfer_done(xfer_done)
    );

    // behavioural reference: 0 idle, 1 params, 2 write, 3 read
    int      m_state = 0;
    int      m_beat = 0;
    longint  m_addr = 0, m_end = 0;
    bit      m_err = 0, m_step = 0, m_done = 0;
    byte unsigned m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_beat = 0; m_addr = 0; m_end = 0;
            m_err = 0; m_step = 0; m_done = 0; m_q.delete();
        end else begin
            m_step = 0; m_done = 0;
            if (rx_stb) begin
                case (m_state)
                    0: if (cmd_flag) begin
                        case (rx_byte)
                            8'h01: begin m_state = 1; m_err = 0; m_q.delete(); end
                            8'h02: begin m_state = 2; m_err = 0; m_beat = 0; end
                            8'h03: begin m_state = 3; m_err = 0; m_beat = 0; end
                            8'h04: m_err = 0;
                            default: m_err = 1;
                        endcase
                    end
                    1: if (!cmd_flag) begin
                        m_q.push_back(rx_byte);
                        if (m_q.size() == 6) begin
                            m_addr = (longint'(m_q[0]) << 16) | (longint'(m_q[1]) << 8) | m_q[2];
                            m_end  = (longint'(m_q[3]) << 16) | (longint'(m_q[4]) << 8) | m_q[5];
                            m_q.delete();
                            m_state = 0;
                        end
                    end
                    default: if (!cmd_flag) begin
                        m_beat++;
                        if (m_beat == 8) begin
                            m_beat = 0;
                            if (m_addr + 8 > m_end) begin m_done = 1; m_state = 0; end
                            else begin m_addr += 8; m_step = 1; end
                        end
                    end
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy == (m_state != 0), "R5 busy", busy, m_state != 0);
            check(wr_active == (m_state == 2), "R5 wr_active", wr_active, m_state == 2);
            check(rd_active == (m_state == 3), "R5 rd_active", rd_active, m_state == 3);
            check(err == m_err, "R8 err", err, m_err);
            check(longint'(word_addr) == m_addr, "R6 word_addr", word_addr, m_addr);
            check(addr_step == m_step, "R6 addr_step", addr_step, m_step);
            check(xfer_done == m_done, "R7 xfer_done", xfer_done, m_done);
        end
    end

    task automatic send(input logic [7:0] b, input logic f);
        rx_byte = b; cmd_flag = f; rx_stb = 1'b1;
        @(negedge clk);
        rx_stb = 1'b0; cmd_flag = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [23:0] s, input logic [23:0] e);
        send(8'h01, 1);
        send(s[23:16], 0); send(s[15:8], 0); send(s[7:0], 0);
        send(e[23:16], 0); send(e[15:8], 0); send(e[7:0], 0);
    endtask

    task automatic words(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            send(8'hA5 ^ 8'(i), 0);
            if (gaps && (i % 3 == 1)) gap(1);
        end
    endtask

    initial begin
        int wd = 0;
        while (!finished && wd < 100000) begin @(posedge clk); wd++; end
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        gap(3);
        @(negedge clk); rst_n = 1'b1;
        gap(1);
        // R1: reset state
        check(!busy && !err && !wr_active && !rd_active && !addr_step && !xfer_done,
              "R1 outputs", {busy, err, wr_active, rd_active}, 0);
        check(word_addr == 0, "R1 word_addr", word_addr, 0);

        // R2: unflagged byte in idle does nothing
        send(8'h02, 0); gap(1);
        check(!busy, "R2 unflagged idle", busy, 0);

        // R4: setup with MSB-first bytes; R3: flagged byte mid-parameter ignored
        send(8'h01, 1);
        check(busy, "R4 busy in setup", busy, 1);
        send(8'h00, 0); send(8'h03, 1); send(8'h00, 0); gap(2); send(8'h10, 0);
        send(8'h00, 0); send(8'h00, 0); send(8'h27, 0);
        check(!busy && word_addr == 24'h000010, "R4 start loaded", word_addr, 24'h10);

        // R10: strobe-free cycles keep everything
        gap(4);
        check(word_addr == 24'h000010 && !busy, "R10 quiet", word_addr, 24'h10);

        // R5/R6/R7: write over three bursts, with gaps and a flagged byte (R3)
        send(8'h02, 1);
        check(wr_active && busy, "R5 write mode", wr_active, 1);
        words(5, 1); send(8'h01, 1); words(11, 1);
        check(word_addr == 24'h000020, "R6 two steps", word_addr, 24'h20);
        words(8, 0);
        check(!busy && word_addr == 24'h000020, "R7 end burst", word_addr, 24'h20);

        // R8/R9: unknown code, stop clears
        send(8'h7E, 1); gap(1);
        check(err && !busy, "R8 unknown code", err, 1);
        send(8'h04, 1); gap(1);
        check(!err && !busy && word_addr == 24'h000020, "R9 stop", err, 0);
        send(8'h00, 1); gap(1);
        check(err, "R8 zero code", err, 1);

        // R7: start above end ends after one burst, read mode
        setup(24'h000100, 24'h000050);
        check(!err, "R8 cleared by setup", err, 0);
        send(8'h03, 1);
        check(rd_active && !wr_active, "R5 read mode", rd_active, 1);
        words(8, 0);
        check(!busy && word_addr == 24'h000100, "R7 start above end", word_addr, 24'h100);

        // R7: top of address range, no wrap
        setup(24'hFFFFF0, 24'hFFFFFF);
        send(8'h02, 1); words(16, 1);
        check(!busy && word_addr == 24'hFFFFF8, "R7 top of range", word_addr, 24'hFFFFF8);

        // R6: back-to-back burst read with unaligned end
        setup(24'h012300, 24'h012331);
        send(8'h03, 1); words(56, 0);
        check(!busy && word_addr == 24'h012330, "R6 seven bursts", word_addr, 24'h12330);

        // R3: flagged setup during transfer ignored
        setup(24'h000000, 24'h00000F);
        send(8'h02, 1); words(3, 0); send(8'h01, 1); send(8'h03, 1); words(5, 0);
        check(wr_active && word_addr == 24'h000008, "R3 cmd in xfer", word_addr, 24'h8);
        words(8, 0);
        check(!busy, "R7 second burst ends", busy, 0);

        gap(3);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule